// File: doc/BRIEF.md
# Bulk-In Transfer Deframer

This block walks one bulk receive transfer, offered a byte at a time with a marker on its final byte, and splits it into the Ethernet frames packed inside. Every frame starts with a 32-bit little-endian status word that gives the frame length and an error summary bit. The payload bytes go out on a ready/valid byte stream with a last marker. The trailing check bytes of each frame and the alignment padding between frames are swallowed.

The block reports how each transfer ended with exactly one single-cycle event. That event is normal completion, a status word cut short by the end of the transfer, a status word with its error bit set, or a length that runs past the end of the transfer. The output is a direct pass-through of the input byte, so back-pressure on the output holds the input.

Top module: `bif_deframer`

## Requirements
- R1: The status word is taken little-endian from four consecutive bytes (first byte is bits 7:0). The frame length is bits 29:16 and the error summary flag is bit 15. All other bits are ignored.
- R2: A frame of length L with L > 4 forwards its first L-4 body bytes in order. The 4 trailing check bytes are consumed and not forwarded. A frame with L <= 4 forwards nothing.
- R3: out_last is high on the final forwarded byte of each frame and on no other forwarded byte.
- R4: After a frame's body, pad bytes are consumed without output until the byte offset from the start of the transfer is a multiple of 4. The next byte is read as the first byte of the next status word.
- R5: If the transfer ends on the 1st, 2nd or 3rd byte of a status word, err_trunc pulses.
- R6: A status word with bit 15 set pulses err_flagged on its 4th byte. No further byte of that transfer is forwarded, and the remaining bytes are consumed up to the end marker.
- R7: If the transfer ends before all L body bytes of a frame arrive, err_oversize pulses on the final byte. If that byte is a payload byte, it is forwarded with out_last high.
- R8: If the transfer ends on the final body byte of a frame, on a pad byte, or on the 4th byte of a status word whose length is 0, xfer_done pulses and no error is raised.
- R9: While a byte is due to be forwarded and out_ready is low, in_ready is low and the byte is held. At all other times in_ready is high.
- R10: Each transfer yields exactly one of xfer_done, err_trunc, err_flagged, err_oversize. The pulse comes in the cycle its byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Transfer byte |
| in_valid | input | 1 | in_data is valid |
| in_end | input | 1 | This byte is the last of the transfer |
| in_ready | output | 1 | Byte is accepted when high together with in_valid |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | out_data is valid |
| out_last | output | 1 | Final payload byte of a frame |
| out_ready | input | 1 | Downstream accepts out_data |
| xfer_done | output | 1 | Pulse: transfer completed without error |
| err_trunc | output | 1 | Pulse: transfer ended inside a status word |
| err_flagged | output | 1 | Pulse: status word error bit set |
| err_oversize | output | 1 | Pulse: frame length exceeds remaining bytes |

## Verification
The bench builds the block with its default parameters: a 14-bit length field at bit 16, the error flag at bit 15, 4 check bytes and 4-byte alignment. With these values, a sweep of frame lengths from 0 to 23 crosses every residue modulo 4 and both sides of the payload/check boundary. Multi-frame transfers with mixed lengths exercise realignment. The bench cuts transfers at every byte position of a status word and of short frames, and repeats all of this under several output-ready patterns and with input gaps.

// File: rtl/bif_pkg.sv
package bif_pkg;

    localparam int unsigned STS_BYTES = 4;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_BODY,
        PH_PAD,
        PH_DRAIN
    } phase_e;

    typedef struct packed {
        logic done;
        logic trunc;
        logic flagged;
        logic oversize;
    } xfer_evt_t;

    function automatic logic len_is_zero(input logic [31:0] v, input int unsigned w);
        logic z;
        z = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(w) && v[i]) z = 1'b0;
        end
        return z;
    endfunction

endpackage

// File: rtl/bif_hdr_asm.sv
module bif_hdr_asm #(
    parameter int unsigned NB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              restart,
    input  logic [7:0]        in_byte,
    output logic              hdr_final,
    output logic [8*NB-1:0]   word
);
    localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

    logic [IW-1:0] idx;

    assign hdr_final = (idx == IW'(NB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (take) begin
            idx <= (restart || hdr_final) ? '0 : idx + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < int'(NB) - 1; g++) begin : g_held
            logic [7:0] held;
            always_ff @(posedge clk) begin
                if (rst) begin
                    held <= '0;
                end else if (take && idx == IW'(g)) begin
                    held <= in_byte;
                end
            end
            assign word[8*g +: 8] = held;
        end
    endgenerate

    assign word[8*(NB-1) +: 8] = in_byte;

endmodule

// File: rtl/bif_align_ctr.sv
module bif_align_ctr #(
    parameter int unsigned AL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic restart,
    output logic wrap
);
    localparam int unsigned PW = (AL > 1) ? $clog2(AL) : 1;

    logic [PW-1:0] pos;

    assign wrap = (pos == PW'(AL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            pos <= (restart || wrap) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/bif_len_ctr.sv
module bif_len_ctr #(
    parameter int unsigned LEN_W = 14,
    parameter int unsigned CHK   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             step,
    output logic             is_payload,
    output logic             is_final_payload,
    output logic             is_final
);
    logic [LEN_W-1:0] rem;

    assign is_payload       = (rem > LEN_W'(CHK));
    assign is_final_payload = (rem == LEN_W'(CHK + 1));
    assign is_final         = (rem == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load) begin
            rem <= len;
        end else if (step) begin
            rem <= rem - 1'b1;
        end
    end

endmodule

// File: rtl/bif_deframer.sv
module bif_deframer
    import bif_pkg::*;
#(
    parameter int unsigned LEN_W       = 14,
    parameter int unsigned LEN_LSB     = 16,
    parameter int unsigned ERR_BIT     = 15,
    parameter int unsigned CHK_BYTES   = 4,
    parameter int unsigned ALIGN_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_end,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    input  logic       out_ready,
    output logic       xfer_done,
    output logic       err_trunc,
    output logic       err_flagged,
    output logic       err_oversize
);
    localparam int unsigned STS_W = 8 * STS_BYTES;

    phase_e            phase, phase_nxt;
    logic              acc, fwd;
    logic              hdr_final;
    logic [STS_W-1:0]  hdr_word;
    logic [LEN_W-1:0]  hdr_len;
    logic              hdr_err, hdr_zero;
    logic              al_wrap;
    logic              len_load;
    logic              is_payload, is_final_payload, is_final;
    xfer_evt_t         evt;
    logic              hdr_unused;

    assign hdr_len    = hdr_word[LEN_LSB +: LEN_W];
    assign hdr_err    = hdr_word[ERR_BIT];
    assign hdr_zero   = len_is_zero(32'(hdr_len), LEN_W);
    assign hdr_unused = ^hdr_word;

    assign fwd       = (phase == PH_BODY) && is_payload;
    assign in_ready  = fwd ? out_ready : 1'b1;
    assign acc       = in_valid && in_ready;
    assign out_data  = in_data;
    assign out_valid = in_valid && fwd;
    assign out_last  = out_valid && (is_final_payload || in_end);

    bif_hdr_asm #(.NB(STS_BYTES)) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .take      (acc && phase == PH_HDR),
        .restart   (in_end),
        .in_byte   (in_data),
        .hdr_final (hdr_final),
        .word      (hdr_word)
    );

    bif_align_ctr #(.AL(ALIGN_BYTES)) u_align (
        .clk     (clk),
        .rst     (rst),
        .step    (acc),
        .restart (in_end),
        .wrap    (al_wrap)
    );

    bif_len_ctr #(.LEN_W(LEN_W), .CHK(CHK_BYTES)) u_len (
        .clk              (clk),
        .rst              (rst),
        .load             (len_load),
        .len              (hdr_len),
        .step             (acc && phase == PH_BODY),
        .is_payload       (is_payload),
        .is_final_payload (is_final_payload),
        .is_final         (is_final)
    );

    always_comb begin
        phase_nxt = phase;
        len_load  = 1'b0;
        evt       = '0;
        unique case (phase)
            PH_HDR: begin
                if (acc) begin
                    if (!hdr_final) begin
                        evt.trunc = in_end;
                    end else if (hdr_err) begin
                        evt.flagged = 1'b1;
                        phase_nxt   = in_end ? PH_HDR : PH_DRAIN;
                    end else if (in_end) begin
                        evt.done     = hdr_zero;
                        evt.oversize = !hdr_zero;
                    end else if (!hdr_zero) begin
                        len_load  = 1'b1;
                        phase_nxt = PH_BODY;
                    end
                end
            end
            PH_BODY: begin
                if (acc) begin
                    if (in_end) begin
                        evt.done     = is_final;
                        evt.oversize = !is_final;
                        phase_nxt    = PH_HDR;
                    end else if (is_final) begin
                        phase_nxt = al_wrap ? PH_HDR : PH_PAD;
                    end
                end
            end
            PH_PAD: begin
                if (acc) begin
                    if (in_end) begin
                        evt.done  = 1'b1;
                        phase_nxt = PH_HDR;
                    end else if (al_wrap) begin
                        phase_nxt = PH_HDR;
                    end
                end
            end
            default: begin
                if (acc && in_end) phase_nxt = PH_HDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_HDR;
        else     phase <= phase_nxt;
    end

    assign xfer_done    = evt.done;
    assign err_trunc    = evt.trunc;
    assign err_flagged  = evt.flagged;
    assign err_oversize = evt.oversize;

endmodule

// File: rtl/bif_deframer_chk.sv
module bif_deframer_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_end,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic xfer_done,
    input logic err_trunc,
    input logic err_flagged,
    input logic err_oversize
);
    p_one_event_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xfer_done, err_trunc, err_flagged, err_oversize}));

    p_event_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (xfer_done || err_trunc || err_flagged || err_oversize) |-> (in_valid && in_ready));

    p_end_events_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer_done || err_trunc || err_oversize) |-> in_end);

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_flag_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        err_flagged |-> !out_valid);

    p_flag_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (err_flagged && !in_end) |=> !out_valid);

endmodule

bind bif_deframer bif_deframer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_end       (in_end),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .xfer_done    (xfer_done),
    .err_trunc    (err_trunc),
    .err_flagged  (err_flagged),
    .err_oversize (err_oversize)
);

// File: tb/bif_deframer_bench.sv
`timescale 1ns/1ps
module bif_deframer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_end = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid, out_last;
    logic       out_ready = 1'b1;
    logic       xfer_done, err_trunc, err_flagged, err_oversize;

    always #4 clk = ~clk;

    bif_deframer u_bif_deframer (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_end(in_end),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready), .xfer_done(xfer_done), .err_trunc(err_trunc),
        .err_flagged(err_flagged), .err_oversize(err_oversize)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] xb [0:1023];
    int xn;
    logic [7:0] ed [0:1023];
    logic       el [0:1023];
    int en, ecode;
    logic [7:0] gd [0:1023];
    logic       gl [0:1023];
    int gn, ev_cnt, ev_code, stall_bad;
    int rmode = 0, gapmode = 0, cyc = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(logic [7:0] b);
        xb[xn] = b;
        xn++;
    endtask

    task automatic add_hdr(int len, bit e, int junk);
        logic [31:0] w;
        w = (32'(junk) & 32'hC000_7FFF) | (32'(len) << 16) | (32'(e) << 15);
        for (int k = 0; k < 4; k++) put(w[8*k +: 8]);
    endtask

    task automatic add_frame(int len, bit e, bit pad, int seed);
        add_hdr(len, e, seed * 32'h1357_2468);
        for (int k = 0; k < len; k++) put(8'((seed * 7 + k * 13 + 1) & 255));
        if (pad) while (xn % 4 != 0) put(8'hEE);
    endtask

    // Expected outputs worked out from the requirements over the whole buffer
    task automatic model();
        int off, avail, len, k;
        logic [31:0] w;
        en = 0; ecode = -1; off = 0;
        while (ecode < 0) begin
            if (off >= xn) ecode = 0;
            else if (xn - off < 4) ecode = 1;
            else begin
                w = {xb[off+3], xb[off+2], xb[off+1], xb[off]};
                if (w[15]) ecode = 2;
                else begin
                    len = int'(w[29:16]);
                    avail = xn - off - 4;
                    k = (len > 4) ? len - 4 : 0;
                    if (len > avail) begin
                        ecode = 3;
                        if (k > avail) k = avail;
                    end
                    for (int j = 0; j < k; j++) begin
                        ed[en] = xb[off + 4 + j];
                        el[en] = (j == k - 1);
                        en++;
                    end
                    off = off + 4 + len;
                    off = ((off + 3) / 4) * 4;
                end
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                2: out_ready = (((cyc * 37) >> 2) % 3) != 0;
                default: out_ready = (cyc % 4) == 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) begin
                gd[gn] = out_data;
                gl[gn] = out_last;
                gn++;
            end
            if (out_valid && !out_ready && in_ready) stall_bad++;
            ev_cnt += int'(xfer_done) + int'(err_trunc) + int'(err_flagged) + int'(err_oversize);
            if (xfer_done)    ev_code = 0;
            if (err_trunc)    ev_code = 1;
            if (err_flagged)  ev_code = 2;
            if (err_oversize) ev_code = 3;
        end
    end

    task automatic run(string what);
        int mis, mis_at, lmis;
        string ctag;
        model();
        gn = 0; ev_cnt = 0; ev_code = -1;
        for (int i = 0; i < xn; i++) begin
            in_data  = xb[i];
            in_valid = 1'b1;
            in_end   = (i == xn - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
            if (gapmode != 0 && i % 3 == 1) begin
                in_valid = 1'b0;
                in_end   = 1'b0;
                @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
        in_end   = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        case (ecode)
            0: ctag = "R8 normal completion";
            1: ctag = "R5 truncated status word";
            2: ctag = "R6 error flagged frame";
            default: ctag = "R7 oversize length";
        endcase
        check(ev_cnt == 1, {"R10 one event per transfer ", what}, ev_cnt, 1);
        check(ev_code == ecode, {ctag, " ", what}, ev_code, ecode);
        check(gn == en, {"R2 forwarded byte count ", what}, gn, en);
        mis = 0; mis_at = 0; lmis = 0;
        for (int i = 0; i < en && i < gn; i++) begin
            if (gd[i] !== ed[i]) begin
                if (mis == 0) mis_at = i;
                mis++;
            end
            if (gl[i] !== el[i]) lmis++;
        end
        if (mis != 0)
            check(0, {"R1 R2 R4 payload bytes ", what}, int'(gd[mis_at]), int'(ed[mis_at]));
        else
            check(1, "R2 payload bytes", 0, 0);
        check(lmis == 0, {"R3 last marker placement ", what}, lmis, 0);
        check(stall_bad == 0, {"R9 input held under back-pressure ", what}, stall_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        stall_bad = 0; gn = 0; ev_cnt = 0; ev_code = -1;
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 reset: no output", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9 reset: input ready", int'(in_ready), 1);
        check((xfer_done | err_trunc | err_flagged | err_oversize) == 1'b0,
              "R10 reset: no event", 1, 0);
        @(posedge clk);
        #1;

        // R1 R2 R3 R8: single frames, every length 0..23, with and without trailing pad
        for (int len = 0; len < 24; len++) begin
            for (int pad = 0; pad < 2; pad++) begin
                rmode = len % 4; gapmode = pad;
                xn = 0;
                add_frame(len, 1'b0, pad[0], len + 3);
                run($sformatf("single len=%0d pad=%0d", len, pad));
            end
        end

        // R4: three frames with mixed residues
        for (int a = 1; a < 10; a++) begin
            for (int b = 3; b < 9; b++) begin
                rmode = (a + b) % 4; gapmode = (a * b) % 2;
                xn = 0;
                add_frame(a, 1'b0, 1'b1, a);
                add_frame(b, 1'b0, 1'b1, b + 40);
                add_frame(a + b, 1'b0, (a % 2) == 1, a + b + 80);
                run($sformatf("multi a=%0d b=%0d", a, b));
            end
        end

        // R5: transfer ends inside a status word
        for (int t = 1; t < 4; t++) begin
            for (int pre = 0; pre < 2; pre++) begin
                rmode = t; gapmode = pre;
                xn = 0;
                if (pre != 0) add_frame(6 + t, 1'b0, 1'b1, t);
                for (int k = 0; k < t; k++) put(8'(k + 1));
                run($sformatf("trunc t=%0d pre=%0d", t, pre));
            end
        end

        // R6: error flag, with trailing bytes, at the end, and first
        for (int v = 0; v < 3; v++) begin
            rmode = v; gapmode = 0;
            xn = 0;
            if (v != 2) add_frame(9, 1'b0, 1'b1, 5);
            add_hdr(8, 1'b1, 0);
            if (v == 0 || v == 2) for (int k = 0; k < 11; k++) put(8'(k + 100));
            run($sformatf("flag v=%0d", v));
        end
        // next transfer after a flagged one starts fresh
        rmode = 0; xn = 0;
        add_frame(10, 1'b0, 1'b1, 9);
        run("R6 recovery");

        // R7: length runs past the end, cut at every body position
        for (int len = 1; len < 13; len++) begin
            for (int cut = 0; cut < len; cut++) begin
                rmode = (len + cut) % 4; gapmode = cut % 2;
                xn = 0;
                if (len % 3 == 0) add_frame(5, 1'b0, 1'b1, len);
                add_hdr(len, 1'b0, len * 77);
                for (int k = 0; k < cut; k++) put(8'(k * 9 + len));
                run($sformatf("oversize len=%0d cut=%0d", len, cut));
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule